// File: doc/BRIEF.md
# BCD Calendar Counter with 12/24-Hour Presentation

This block keeps wall-clock time and calendar date as packed BCD fields: seconds, minutes, hours, weekday, day of month, month, and a two-digit year that counts from 2000. Each tick-enable pulse advances the time by one second. Every field rolls over at its own limit and carries into the next field. The day of month follows the length of the current month. February has 29 days in any year whose two-digit value is a multiple of four.

Hours are stored internally as a 24-hour count. Software can write and read them in either 24-hour or 12-hour form. The form is chosen by a mode bit carried in the hour byte itself. Each field is written on its own through a field selector. A capture request latches a seven-byte image of all fields into a snapshot register. That register is read by whatever logic sits above the block.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields hold 00:00:00 in 24-hour mode, weekday 1, date 01, month 01 and year 00. `snap_out` is all zeros and `snap_valid` is low.
- R2: The snapshot is laid out one byte per field, starting from the least significant byte: seconds at [7:0], minutes at [15:8], hour byte at [23:16], weekday at [31:24], date at [39:32], month at [47:40] and year at [55:48].
- R3: A tick advances seconds by one. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours. Hours 23 wraps to 00 and carries into weekday and date.
- R4: In the hour byte, bit 6 set means 12-hour presentation and bit 5 is the PM flag. In 12-hour mode, internal hour 0 reads as 0x52 (12 AM), hours 1 to 11 read as 0x40 plus their BCD value, hour 12 reads as 0x72 (12 PM), and hours 13 to 23 read as 0x60 plus the BCD of hour minus 12. In 24-hour mode the byte is the plain BCD hour 00 to 23.
- R5: A write to the hour field (selector 2) sets the mode from data bit 6. With bit 6 clear, bits 5:0 are a BCD hour 00 to 23. With bit 6 set, bits 4:0 are a BCD hour 1 to 12 and bit 5 means PM, so 12 AM stores 0, 12 PM stores 12 and 11 PM stores 23.
- R6: The weekday counts 1 to 7 and advances at midnight, with 7 followed by 1. A write to selector 3 loads data bits 2:0.
- R7: The date wraps to 01 after the last day of the month. That last day is 30 for months 04, 06, 09 and 11, 31 for every other month except February, and for February 29 when the year is a multiple of four and 28 otherwise.
- R8: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R9: Writes are masked. Seconds (selector 0) and minutes (selector 1) keep data bits 6:0, date (selector 4) keeps bits 5:0, month (selector 5) keeps bits 4:0, and year (selector 6) keeps all eight bits.
- R10: In a cycle with `wr_en` high, the write is applied and a coincident tick is dropped entirely.
- R11: `snap_valid` is high exactly in the cycle after a `cap_req`. In that cycle `snap_out` shows the fields as they stand after any write or tick applied in the request cycle. `snap_out` then holds until the next capture.
- R12: A write with selector 7 changes no field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-second advance pulse |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector: 0 sec, 1 min, 2 hour, 3 weekday, 4 date, 5 month, 6 year |
| wr_data | input | 8 | Write data in register encoding |
| cap_req | input | 1 | Capture request |
| snap_out | output | 56 | Seven-byte snapshot image |
| snap_valid | output | 1 | High in the cycle after a capture request |

## Verification
The bench goes after the carry chain at its full depth: a tick at 23:59:59 on 31 December of year 99 must clear every field. A design whose carry stops early would leave a stale date or year. The month-end checks cover 30-day months, February in leap and common years, and a 31-day month. A wrong length table shows up as a 31 April or a skipped 29 February. In 12-hour mode the bench writes and reads 12 AM, 12 PM and 11 PM and ticks across noon and midnight. A codec that does not special-case the value 12 would show 00 or shift the PM flag by one hour. Further checks cover a write that coincides with a tick, writes with the masked-off bits set, and selector 7. A design that let the tick through or kept a masked bit would show a changed seconds value or a field outside its range.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BYTE_W  = 8;
  localparam int NFIELD  = 7;
  localparam int SNAP_W  = BYTE_W * NFIELD;
  localparam int SEL_W   = 3;

  localparam logic [SEL_W-1:0] SEL_SEC  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_MIN  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_HOUR = 3'd2;
  localparam logic [SEL_W-1:0] SEL_WDAY = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DATE = 3'd4;
  localparam logic [SEL_W-1:0] SEL_MON  = 3'd5;
  localparam logic [SEL_W-1:0] SEL_YEAR = 3'd6;

  localparam logic [BYTE_W-1:0] HR_MODE12 = 8'h40;
  localparam logic [BYTE_W-1:0] HR_PM     = 8'h20;

  // Two-digit BCD increment without wrap handling.
  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [BYTE_W-1:0] v);
    return 7'({3'b000, v[7:4]} * 7'd10 + {3'b000, v[3:0]});
  endfunction

  function automatic logic [BYTE_W-1:0] bin_to_bcd(input logic [6:0] b);
    return {4'(b / 7'd10), 4'(b % 7'd10)};
  endfunction
endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_VAL = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic [BYTE_W-1:0] lo,
  input  logic [BYTE_W-1:0] hi,
  output logic [BYTE_W-1:0] val,
  output logic [BYTE_W-1:0] val_next,
  output logic              wrap
);
  logic [BYTE_W-1:0] val_q;
  logic [BYTE_W-1:0] val_d;
  logic              at_top;
  logic              upd_en;

  assign at_top = (val_q >= hi);
  assign upd_en = load | inc;
  assign wrap   = inc & ~load & at_top;

  always_comb begin
    val_d = val_q;
    if (load)      val_d = load_val;
    else if (inc)  val_d = at_top ? lo : bcd_inc(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= RESET_VAL;
    else if (upd_en) val_q <= val_d;
  end

  assign val      = val_q;
  assign val_next = val_d;
endmodule

// File: rtl/cal_hour_codec.sv
module cal_hour_codec
  import cal_pkg::*;
(
  input  logic [BYTE_W-1:0] hour24,
  input  logic              mode12,
  input  logic [6:0]        wr_byte,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] wr_hour24,
  output logic              wr_mode12
);
  logic [6:0] hb;
  logic [6:0] wb;

  // Internal 24-hour count to register byte.
  always_comb begin
    hb = bcd_to_bin(hour24);
    if (!mode12)             rd_byte = hour24;
    else if (hb == 7'd0)     rd_byte = HR_MODE12 | 8'h12;
    else if (hb < 7'd12)     rd_byte = HR_MODE12 | bin_to_bcd(hb);
    else if (hb == 7'd12)    rd_byte = HR_MODE12 | HR_PM | 8'h12;
    else                     rd_byte = HR_MODE12 | HR_PM | bin_to_bcd(hb - 7'd12);
  end

  // Register byte to internal 24-hour count.
  always_comb begin
    wr_mode12 = wr_byte[6];
    wb        = bcd_to_bin({3'b000, wr_byte[4:0]});
    if (wr_byte[5]) wb = wb + 7'd12;
    if (wb == 7'd12 || wb == 7'd24) wb = wb - 7'd12;
    if (!wr_byte[6]) wr_hour24 = {2'b00, wr_byte[5:0]};
    else             wr_hour24 = bin_to_bcd(wb);
  end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  logic [BYTE_W-1:0] month,
  input  logic [BYTE_W-1:0] year,
  output logic [BYTE_W-1:0] last_day
);
  logic [6:0] ybin;
  logic       leap;

  always_comb begin
    ybin = bcd_to_bin(year);
    leap = (ybin[1:0] == 2'b00);
    unique case (month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cap_req,
  output logic [SNAP_W-1:0] snap_out,
  output logic              snap_valid
);
  logic rst_n_sync;

  cal_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk      (clk),
    .arst_n   (rst_n),
    .rst_n_out(rst_n_sync)
  );

  // Write decode; a write cancels the tick of its cycle.
  logic tick_go;
  logic hit_sec, hit_min, hit_hour, hit_wday, hit_date, hit_mon, hit_year;

  assign tick_go  = tick_en & ~wr_en;
  assign hit_sec  = wr_en & (wr_sel == SEL_SEC);
  assign hit_min  = wr_en & (wr_sel == SEL_MIN);
  assign hit_hour = wr_en & (wr_sel == SEL_HOUR);
  assign hit_wday = wr_en & (wr_sel == SEL_WDAY);
  assign hit_date = wr_en & (wr_sel == SEL_DATE);
  assign hit_mon  = wr_en & (wr_sel == SEL_MON);
  assign hit_year = wr_en & (wr_sel == SEL_YEAR);

  logic [BYTE_W-1:0] sec_v,  sec_n;
  logic [BYTE_W-1:0] min_v,  min_n;
  logic [BYTE_W-1:0] hour_v, hour_n;
  logic [BYTE_W-1:0] wday_v, wday_n;
  logic [BYTE_W-1:0] date_v, date_n;
  logic [BYTE_W-1:0] mon_v,  mon_n;
  logic [BYTE_W-1:0] year_v, year_n;
  logic sec_wrap, min_wrap, hour_wrap, wday_wrap, date_wrap, mon_wrap, year_wrap;

  logic [BYTE_W-1:0] hour_wr_val;
  logic              hour_wr_mode;
  logic [BYTE_W-1:0] hour_rd;
  logic [BYTE_W-1:0] month_last;
  logic              mode_q, mode_d;

  cal_hour_codec u_codec (
    .hour24   (hour_n),
    .mode12   (mode_d),
    .wr_byte  (wr_data[6:0]),
    .rd_byte  (hour_rd),
    .wr_hour24(hour_wr_val),
    .wr_mode12(hour_wr_mode)
  );

  cal_month_len u_mlen (
    .month   (mon_v),
    .year    (year_v),
    .last_day(month_last)
  );

  cal_bcd_field #(.RESET_VAL(8'h00)) u_sec (
    .clk(clk), .rst_n(rst_n_sync), .inc(tick_go), .load(hit_sec),
    .load_val({1'b0, wr_data[6:0]}), .lo(8'h00), .hi(8'h59),
    .val(sec_v), .val_next(sec_n), .wrap(sec_wrap)
  );

  cal_bcd_field #(.RESET_VAL(8'h00)) u_min (
    .clk(clk), .rst_n(rst_n_sync), .inc(sec_wrap), .load(hit_min),
    .load_val({1'b0, wr_data[6:0]}), .lo(8'h00), .hi(8'h59),
    .val(min_v), .val_next(min_n), .wrap(min_wrap)
  );

  cal_bcd_field #(.RESET_VAL(8'h00)) u_hour (
    .clk(clk), .rst_n(rst_n_sync), .inc(min_wrap), .load(hit_hour),
    .load_val(hour_wr_val), .lo(8'h00), .hi(8'h23),
    .val(hour_v), .val_next(hour_n), .wrap(hour_wrap)
  );

  cal_bcd_field #(.RESET_VAL(8'h01)) u_wday (
    .clk(clk), .rst_n(rst_n_sync), .inc(hour_wrap), .load(hit_wday),
    .load_val({5'b00000, wr_data[2:0]}), .lo(8'h01), .hi(8'h07),
    .val(wday_v), .val_next(wday_n), .wrap(wday_wrap)
  );

  cal_bcd_field #(.RESET_VAL(8'h01)) u_date (
    .clk(clk), .rst_n(rst_n_sync), .inc(hour_wrap), .load(hit_date),
    .load_val({2'b00, wr_data[5:0]}), .lo(8'h01), .hi(month_last),
    .val(date_v), .val_next(date_n), .wrap(date_wrap)
  );

  cal_bcd_field #(.RESET_VAL(8'h01)) u_mon (
    .clk(clk), .rst_n(rst_n_sync), .inc(date_wrap), .load(hit_mon),
    .load_val({3'b000, wr_data[4:0]}), .lo(8'h01), .hi(8'h12),
    .val(mon_v), .val_next(mon_n), .wrap(mon_wrap)
  );

  cal_bcd_field #(.RESET_VAL(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n_sync), .inc(mon_wrap), .load(hit_year),
    .load_val(wr_data), .lo(8'h00), .hi(8'h99),
    .val(year_v), .val_next(year_n), .wrap(year_wrap)
  );

  // Hour presentation mode, set only by an hour write.
  always_comb begin
    mode_d = mode_q;
    if (hit_hour) mode_d = hour_wr_mode;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) mode_q <= 1'b0;
    else if (hit_hour) mode_q <= mode_d;
  end

  // Snapshot register: captures the post-update image of the request cycle.
  logic [SNAP_W-1:0] snap_q, snap_d;
  logic              valid_q;

  always_comb begin
    snap_d = {year_n, mon_n, date_n, wday_n, hour_rd, min_n, sec_n};
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  snap_q <= '0;
    else if (cap_req) snap_q <= snap_d;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) valid_q <= 1'b0;
    else             valid_q <= cap_req;
  end

  assign snap_out   = snap_q;
  assign snap_valid = valid_q;

  // Wrap of the last fields feeds nothing further.
  logic unused_wraps;
  assign unused_wraps = wday_wrap ^ year_wrap;
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
  import cal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [BYTE_W-1:0] wr_data,
  input logic              cap_req,
  input logic [SNAP_W-1:0] snap_out,
  input logic              snap_valid,
  input logic [BYTE_W-1:0] sec_v,
  input logic [BYTE_W-1:0] min_v,
  input logic [BYTE_W-1:0] hour_v,
  input logic [BYTE_W-1:0] wday_v
);
  // R11: a capture request yields snap_valid in the next cycle
  a_r11_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req |=> snap_valid);

  // R11: no request, no valid
  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_req |=> !snap_valid);

  // R11: snapshot holds between captures
  a_r11_snap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_req |=> $stable(snap_out));

  // R3: seconds wrap on a tick at 59
  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_en && sec_v == 8'h59) |=> (sec_v == 8'h00));

  // R10 and R9: a seconds write wins over a tick and drops bit 7
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_SEC) |=> (sec_v == {1'b0, $past(wr_data[6:0])}));

  // R6: weekday 7 is followed by 1 at midnight
  a_r6_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_en && sec_v == 8'h59 && min_v == 8'h59 &&
     hour_v == 8'h23 && wday_v == 8'h07) |=> (wday_v == 8'h01));

  // R4: a 12-hour byte never shows hour zero
  a_r4_no_zero_hour12: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_valid && snap_out[22]) |-> (snap_out[20:16] != 5'd0));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .tick_en   (tick_en),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .cap_req   (cap_req),
  .snap_out  (snap_out),
  .snap_valid(snap_valid),
  .sec_v     (sec_v),
  .min_v     (min_v),
  .hour_v    (hour_v),
  .wday_v    (wday_v)
);

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [7:0]  wr_data;
  logic        cap_req;
  logic [55:0] snap_out;
  logic        snap_valid;

  int n_cmp;
  int n_bad;
  bit done;

  // Behavioural model state (binary integers)
  int se, mi, hr, wd, dt, mo, yr, m12;
  logic [55:0] exp_snap;
  logic        exp_valid;

  bcd_calendar dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .cap_req(cap_req),
    .snap_out(snap_out), .snap_valid(snap_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] tobcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int frombcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] enc_hour(input int h, input int mode);
    int disp;
    if (mode == 0) return tobcd(h);
    disp = h % 12;
    if (disp == 0) disp = 12;
    return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | tobcd(disp);
  endfunction

  task automatic model_write(input logic [2:0] s, input logic [7:0] d);
    int v;
    case (s)
      3'd0: se = frombcd(d & 8'h7F);
      3'd1: mi = frombcd(d & 8'h7F);
      3'd2: begin
        m12 = d[6] ? 1 : 0;
        if (d[6]) begin
          v = frombcd(d & 8'h1F) % 12;
          if (d[5]) v = v + 12;
          hr = v;
        end else hr = frombcd(d & 8'h3F);
      end
      3'd3: wd = int'(d[2:0]);
      3'd4: dt = frombcd(d & 8'h3F);
      3'd5: mo = frombcd(d & 8'h1F);
      3'd6: yr = frombcd(d);
      default: ;
    endcase
  endtask

  task automatic model_tick();
    if (se < 59) begin se++; return; end
    se = 0;
    if (mi < 59) begin mi++; return; end
    mi = 0;
    if (hr < 23) begin hr++; return; end
    hr = 0;
    wd = (wd >= 7) ? 1 : wd + 1;
    if (dt < mdays(mo, yr)) begin dt++; return; end
    dt = 1;
    if (mo < 12) begin mo++; return; end
    mo = 1;
    yr = (yr >= 99) ? 0 : yr + 1;
  endtask

  task automatic step(input bit t, input bit w, input logic [2:0] s,
                      input logic [7:0] d, input bit c, input string tag);
    tick_en = t; wr_en = w; wr_sel = s; wr_data = d; cap_req = c;
    @(posedge clk);
    if (w) model_write(s, d);
    else if (t) model_tick();
    exp_valid = c;
    if (c) exp_snap = {tobcd(yr), tobcd(mo), tobcd(dt), 8'(wd),
                       enc_hour(hr, m12), tobcd(mi), tobcd(se)};
    @(negedge clk);
    n_cmp++;
    if (snap_valid !== exp_valid || snap_out !== exp_snap) begin
      n_bad++;
      $display("FAIL %s: actual valid=%0b snap=%h expected valid=%0b snap=%h",
               tag, snap_valid, snap_out, exp_valid, exp_snap);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d, input string tag);
    step(1'b0, 1'b1, s, d, 1'b0, tag);
  endtask

  task automatic cap(input string tag);
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, tag);
  endtask

  task automatic tk(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, 8'h00, 1'b1, tag);
  endtask

  task automatic set_eod(input logic [7:0] hbyte, input string tag);
    wr(3'd0, 8'h59, tag);
    wr(3'd1, 8'h59, tag);
    wr(3'd2, hbyte, tag);
  endtask

  function automatic logic [7:0] rnd_field(input int s);
    case (s)
      0, 1: return tobcd($urandom_range(0, 59));
      2: begin
        if ($urandom_range(0, 1) == 0) return tobcd($urandom_range(0, 23));
        return 8'h40 | ($urandom_range(0, 1) == 1 ? 8'h20 : 8'h00)
                     | tobcd($urandom_range(1, 12));
      end
      3: return 8'($urandom_range(1, 7));
      4: return tobcd($urandom_range(1, 28));
      5: return tobcd($urandom_range(1, 12));
      default: return tobcd($urandom_range(0, 99));
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11: watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    se = 0; mi = 0; hr = 0; wd = 1; dt = 1; mo = 1; yr = 0; m12 = 0;
    exp_snap = '0; exp_valid = 1'b0;
    rst_n = 1'b0; tick_en = 0; wr_en = 0; wr_sel = 0; wr_data = 0; cap_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset image, idle while the reset synchronizer releases
    for (int i = 0; i < 4; i++) step(0, 0, 3'd0, 8'h00, 0, "R1");
    cap("R1");
    // R2, R3: plain ticks
    tk(3, "R2");
    // R9: seconds bit 7 ignored; R3: minute carry
    wr(3'd0, 8'hD8, "R9");
    cap("R9");
    tk(3, "R3");
    wr(3'd1, 8'hC5, "R9");
    cap("R9");
    // R8, R6, R3: full carry chain to a new century
    wr(3'd3, 8'h07, "R6");
    wr(3'd4, 8'h31, "R8");
    wr(3'd5, 8'h12, "R8");
    wr(3'd6, 8'h99, "R8");
    set_eod(8'h23, "R8");
    tk(2, "R8");
    // R7: leap February
    wr(3'd6, 8'h24, "R7"); wr(3'd5, 8'h02, "R7"); wr(3'd4, 8'h28, "R7");
    set_eod(8'h23, "R7"); tk(2, "R7");
    set_eod(8'h23, "R7"); tk(2, "R7");
    // R7: common February
    wr(3'd6, 8'h23, "R7"); wr(3'd5, 8'h02, "R7"); wr(3'd4, 8'h28, "R7");
    set_eod(8'h23, "R7"); tk(2, "R7");
    // R7: 30-day and 31-day months
    wr(3'd5, 8'h04, "R7"); wr(3'd4, 8'h30, "R7");
    set_eod(8'h23, "R7"); tk(2, "R7");
    wr(3'd5, 8'h01, "R7"); wr(3'd4, 8'h30, "R7");
    set_eod(8'h23, "R7"); tk(2, "R7");
    wr(3'd5, 8'h11, "R7"); wr(3'd4, 8'h30, "R7");
    set_eod(8'h23, "R7"); tk(2, "R7");
    // R5, R4: 12-hour writes and presentation
    wr(3'd2, 8'h52, "R5"); cap("R5");
    wr(3'd2, 8'h72, "R5"); cap("R5");
    wr(3'd2, 8'h71, "R5"); cap("R5");
    set_eod(8'h51, "R4"); tk(2, "R4");
    set_eod(8'h72, "R4"); tk(2, "R4");
    set_eod(8'h71, "R4"); tk(2, "R4");
    wr(3'd2, 8'h13, "R5"); cap("R5");
    // R10: write and tick together, then capture in same cycle as a write
    step(1, 1, 3'd1, 8'h30, 1, "R10");
    step(1, 1, 3'd0, 8'h10, 1, "R10");
    // R12: selector 7 changes nothing
    wr(3'd7, 8'h45, "R12"); cap("R12");
    // R9: date and month masks
    wr(3'd4, 8'hE5, "R9"); wr(3'd5, 8'hE9, "R9"); cap("R9");
    // R6: weekday write keeps low 3 bits
    wr(3'd3, 8'hFB, "R6"); cap("R6");
    // R11: capture holds while idle and ticking
    tk(1, "R11");
    for (int i = 0; i < 5; i++) step(1, 0, 3'd0, 8'h00, 0, "R11");
    cap("R11");
    // Mixed traffic with periodic end-of-day presets
    for (int i = 0; i < 6000; i++) begin
      if (i % 300 == 0) begin
        wr(3'd4, tobcd(mdays(mo, yr)), "R7");
        set_eod(($urandom_range(0, 1) == 1) ? 8'h71 : 8'h23, "R3");
      end else if ($urandom_range(0, 49) == 0) begin
        int s;
        s = $urandom_range(0, 7);
        step($urandom_range(0, 1) == 1, 1, 3'(s), rnd_field(s),
             $urandom_range(0, 1) == 1, "R10");
      end else begin
        step($urandom_range(0, 3) != 0, 0, 3'd0, 8'h00,
             $urandom_range(0, 1) == 1, "R11");
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule